// File: doc/BRIEF.md
# I2C Combined-Format Read Sequencer

This block is an I2C bus master that runs one sequential read from a slave device for each command it accepts. In indexed mode it first performs a dummy write. That write sends the device address with the write direction, then the one-byte register index that loads the slave's read pointer. The block then issues a repeated start without a stop, sends the device address again with the read direction, and clocks in the requested number of bytes. In plain mode the write phase is skipped: the read address byte follows the start condition directly. This mode suits slaves that have no internal addressing.

Each received byte is presented on a parallel output with a one-cycle valid strobe, in bus order. A busy level covers the whole transaction. A one-cycle completion pulse ends it, and it carries an error pulse when the slave refused an address or index byte. The bus pins are open-drain: the block only asserts pull-low enables, and the SCL rate comes from a quarter-period divider input.

Top module: `i2c_rdseq`

## Requirements
- R1: In indexed mode (use_index = 1) the bus carries, in order: a start condition, the byte {dev_addr, 0}, the byte reg_index, a repeated start with no stop before it, the byte {dev_addr, 1}, rd_count data bytes, and a stop condition. The device address occupies bits 7..1 of an address byte and the direction bit occupies bit 0 (1 = read). Bytes are sent most significant bit first.
- R2: In plain mode (use_index = 0) the bus carries exactly one start condition, the byte {dev_addr, 1}, rd_count data bytes and a stop condition, with no write phase.
- R3: Exactly rd_count bytes are delivered on rd_data, each with a one-cycle rd_valid pulse, in the order they appeared on the bus. rd_valid is only asserted while busy is high.
- R4: The master drives ACK (SDA low) in the acknowledge slot of every received byte except the last, and leaves SDA released (NACK) after the last byte.
- R5: While SCL is released, SDA changes only as a start, repeated start or stop condition (high to low for a start, low to high for a stop). Data and acknowledge levels change only while SCL is low.
- R6: If the slave does not acknowledge an address byte or the index byte, the block sends a stop and ends the command with done and nack_err pulsed together, and delivers no data bytes.
- R7: Every SCL high phase between a falling and a rising edge of SCL inside a transaction lasts exactly 2*(quarter_div+1) clock cycles.
- R8: scl_pull and sda_pull are pull-low enables (1 = drive the line low, 0 = release). Both are 0 after reset and after every completed command.
- R9: A go pulse with rd_count = 0 is ignored: busy stays low, done does not pulse and the bus stays idle.
- R10: A go pulse while busy is high is ignored: the running command completes with its own parameters and no second command follows.
- R11: busy rises on the cycle after an accepted go and falls on the same cycle that the one-cycle done pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| quarter_div | input | DIV_W | SCL quarter period is quarter_div+1 clock cycles |
| go | input | 1 | Command strobe, accepted only when idle with a non-zero count |
| use_index | input | 1 | 1 = dummy write with index before the read, 0 = plain read |
| dev_addr | input | 7 | Seven-bit slave address |
| reg_index | input | 8 | Register index sent in the dummy write |
| rd_count | input | CNT_W | Number of bytes to read |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle pulse when a command ends |
| nack_err | output | 1 | One-cycle pulse with done when the slave refused a byte |
| rd_valid | output | 1 | One-cycle strobe for rd_data |
| rd_data | output | 8 | Received byte |
| scl_pull | output | 1 | Pull SCL low when 1 |
| sda_pull | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Resolved SDA line level |

## Verification
The bench attaches a behavioural slave whose memory contents are a computed function of the address, so every data byte can be predicted from the index and the slave's pointer. The key corner cases are a single-byte read and the skipped write phase. In a single-byte read, a design that acknowledged the only byte would show one ACK where none is expected. In plain mode, a design that left the write phase in would log extra address bytes at the slave and read from the wrong pointer. Refused address and index bytes are injected; a design that continued would deliver data or miss the error pulse. A go strobe during a command and a go with a zero count check that stray strobes neither restart nor start the bus. SCL high widths are measured at every divider setting, which exposes an off-by-one in the divider.

// File: rtl/i2c_rdseq_pkg.sv
// Shared definitions for the combined-format read sequencer.
// Assumes: byte-level bus commands are issued one at a time.
package i2c_rdseq_pkg;

    localparam int unsigned BITS_PER_BYTE = 8;

    // Bus-level operations that the bit engine can perform
    typedef enum logic [2:0] {
        BC_NONE,
        BC_START,
        BC_RSTART,
        BC_STOP,
        BC_WRITE,
        BC_READ
    } bus_cmd_e;

    // Transaction phases of the sequencer
    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_START,
        SQ_WADDR,
        SQ_INDEX,
        SQ_RSTART,
        SQ_RADDR,
        SQ_DATA,
        SQ_STOP
    } seq_state_e;

endpackage

// File: rtl/i2c_quarter_tick.sv
// Free-running divider producing a one-cycle tick every quarter_div+1 cycles.
// Assumes: quarter_div is changed only while the bus is idle; a lower value
// takes effect at once because the compare is >=.
module i2c_quarter_tick #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] quarter_div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;

    // Count cycles and emit a tick at the end of each quarter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= quarter_div) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end

endmodule

// File: rtl/i2c_bit_engine.sv
// Executes one bus operation (start, repeated start, stop, byte write with
// acknowledge capture, byte read with acknowledge drive) as a sequence of
// four quarters per bit. Line levels are registered pull-low enables, held
// between operations.
// Assumes: a new command is only presented while the engine is idle; sda_in
// is the resolved line level; SCL is not stretched by the slave.
module i2c_bit_engine
    import i2c_rdseq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tick,
    input  logic     cmd_valid,
    input  bus_cmd_e cmd,
    input  logic [7:0] tx_byte,
    input  logic     ack_send,
    input  logic     sda_in,
    output logic     done,
    output logic [7:0] rx_byte,
    output logic     ack_seen,
    output logic     scl_pull,
    output logic     sda_pull
);

    localparam logic [3:0] ACK_SLOT = 4'(BITS_PER_BYTE);

    logic       active;
    bus_cmd_e   cmd_q;
    logic [1:0] qtr;
    logic [3:0] bidx;
    logic [7:0] shreg;
    logic       samp;
    logic       ack_send_q;
    logic       is_byte;
    logic       last_step;
    logic       scl_rel;
    logic       sda_rel;

    assign is_byte   = (cmd_q == BC_WRITE) || (cmd_q == BC_READ);
    assign last_step = (qtr == 2'd3) && (!is_byte || (bidx == ACK_SLOT));
    assign rx_byte   = shreg;

    // Line levels wanted in the current quarter of the current operation
    always_comb begin
        scl_rel = 1'b1;
        sda_rel = 1'b1;
        unique case (cmd_q)
            BC_START: begin
                scl_rel = (qtr != 2'd3);
                sda_rel = (qtr < 2'd2);
            end
            BC_RSTART: begin
                scl_rel = (qtr == 2'd1) || (qtr == 2'd2);
                sda_rel = (qtr < 2'd2);
            end
            BC_STOP: begin
                scl_rel = (qtr != 2'd0);
                sda_rel = (qtr >= 2'd2);
            end
            BC_WRITE: begin
                scl_rel = (qtr == 2'd1) || (qtr == 2'd2);
                sda_rel = (bidx < ACK_SLOT) ? shreg[7] : 1'b1;
            end
            BC_READ: begin
                scl_rel = (qtr == 2'd1) || (qtr == 2'd2);
                sda_rel = (bidx < ACK_SLOT) ? 1'b1 : !ack_send_q;
            end
            default: begin
                scl_rel = 1'b1;
                sda_rel = 1'b1;
            end
        endcase
    end

    // Register the pull enables while an operation runs, hold them otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pull <= 1'b0;
            sda_pull <= 1'b0;
        end else if (active) begin
            scl_pull <= !scl_rel;
            sda_pull <= !sda_rel;
        end
    end

    // Step quarters and bits, sample SDA in the high phase, shift at bit end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active     <= 1'b0;
            cmd_q      <= BC_NONE;
            qtr        <= 2'd0;
            bidx       <= 4'd0;
            shreg      <= 8'h00;
            samp       <= 1'b1;
            ack_send_q <= 1'b0;
            ack_seen   <= 1'b0;
            done       <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!active) begin
                if (cmd_valid) begin
                    active     <= 1'b1;
                    cmd_q      <= cmd;
                    qtr        <= 2'd0;
                    bidx       <= 4'd0;
                    shreg      <= tx_byte;
                    ack_send_q <= ack_send;
                end
            end else if (tick) begin
                qtr <= qtr + 2'd1;
                if (qtr == 2'd1) begin
                    samp <= sda_in;
                end
                if (qtr == 2'd3) begin
                    if (is_byte) begin
                        if (bidx < ACK_SLOT) begin
                            shreg <= {shreg[6:0], samp};
                        end else begin
                            ack_seen <= !samp;
                        end
                        bidx <= bidx + 4'd1;
                    end
                    if (last_step) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                    end
                end
            end
        end
    end

    // R5: with SCL released on both cycles, SDA may move only in a start/stop
    a_r5_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_pull && !$past(scl_pull) && (sda_pull != $past(sda_pull)))
            |-> (cmd_q inside {BC_START, BC_RSTART, BC_STOP}));

    // R8: the lines are frozen while no operation runs
    a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> ($stable(scl_pull) && $stable(sda_pull)));

endmodule

// File: rtl/i2c_rdseq.sv
// Combined-format read sequencer: accepts a command (device address, index,
// byte count, mode) and drives the bit engine through start, optional dummy
// write with index, repeated start, read address and N data reads, then stop.
// Aborts with a stop on any refused address or index byte.
// Assumes: a single master on the bus, no clock stretching, sda_in is the
// resolved open-drain SDA level.
module i2c_rdseq
    import i2c_rdseq_pkg::*;
#(
    parameter int unsigned DIV_W = 8,
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] quarter_div,
    input  logic             go,
    input  logic             use_index,
    input  logic [6:0]       dev_addr,
    input  logic [7:0]       reg_index,
    input  logic [CNT_W-1:0] rd_count,
    output logic             busy,
    output logic             done,
    output logic             nack_err,
    output logic             rd_valid,
    output logic [7:0]       rd_data,
    output logic             scl_pull,
    output logic             sda_pull,
    input  logic             sda_in
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_TWO = CNT_W'(2);

    seq_state_e       st;
    logic [6:0]       addr_q;
    logic [7:0]       idx_q;
    logic             mode_q;
    logic [CNT_W-1:0] left_q;
    logic             fail_q;
    logic             cmd_vld;
    bus_cmd_e         cmd_sel;
    logic [7:0]       cmd_byte;
    logic             cmd_ack;
    logic             tick;
    logic             eng_done;
    logic [7:0]       eng_rx;
    logic             eng_ack;

    assign busy = (st != SQ_IDLE);

    i2c_quarter_tick #(.DIV_W(DIV_W)) u_tick (
        .clk         (clk),
        .rst_n       (rst_n),
        .quarter_div (quarter_div),
        .tick        (tick)
    );

    i2c_bit_engine u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .cmd_valid (cmd_vld),
        .cmd       (cmd_sel),
        .tx_byte   (cmd_byte),
        .ack_send  (cmd_ack),
        .sda_in    (sda_in),
        .done      (eng_done),
        .rx_byte   (eng_rx),
        .ack_seen  (eng_ack),
        .scl_pull  (scl_pull),
        .sda_pull  (sda_pull)
    );

    // Advance the transaction on each finished bus operation and queue the next
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= SQ_IDLE;
            addr_q   <= 7'h00;
            idx_q    <= 8'h00;
            mode_q   <= 1'b0;
            left_q   <= '0;
            fail_q   <= 1'b0;
            cmd_vld  <= 1'b0;
            cmd_sel  <= BC_NONE;
            cmd_byte <= 8'h00;
            cmd_ack  <= 1'b0;
            done     <= 1'b0;
            nack_err <= 1'b0;
            rd_valid <= 1'b0;
            rd_data  <= 8'h00;
        end else begin
            cmd_vld  <= 1'b0;
            done     <= 1'b0;
            nack_err <= 1'b0;
            rd_valid <= 1'b0;
            unique case (st)
                SQ_IDLE: begin
                    if (go && (rd_count != '0)) begin
                        addr_q  <= dev_addr;
                        idx_q   <= reg_index;
                        mode_q  <= use_index;
                        left_q  <= rd_count;
                        fail_q  <= 1'b0;
                        cmd_vld <= 1'b1;
                        cmd_sel <= BC_START;
                        st      <= SQ_START;
                    end
                end
                SQ_START: begin
                    if (eng_done) begin
                        cmd_vld  <= 1'b1;
                        cmd_sel  <= BC_WRITE;
                        cmd_byte <= {addr_q, !mode_q};
                        st       <= mode_q ? SQ_WADDR : SQ_RADDR;
                    end
                end
                SQ_WADDR: begin
                    if (eng_done) begin
                        cmd_vld <= 1'b1;
                        if (eng_ack) begin
                            cmd_sel  <= BC_WRITE;
                            cmd_byte <= idx_q;
                            st       <= SQ_INDEX;
                        end else begin
                            cmd_sel <= BC_STOP;
                            fail_q  <= 1'b1;
                            st      <= SQ_STOP;
                        end
                    end
                end
                SQ_INDEX: begin
                    if (eng_done) begin
                        cmd_vld <= 1'b1;
                        if (eng_ack) begin
                            cmd_sel <= BC_RSTART;
                            st      <= SQ_RSTART;
                        end else begin
                            cmd_sel <= BC_STOP;
                            fail_q  <= 1'b1;
                            st      <= SQ_STOP;
                        end
                    end
                end
                SQ_RSTART: begin
                    if (eng_done) begin
                        cmd_vld  <= 1'b1;
                        cmd_sel  <= BC_WRITE;
                        cmd_byte <= {addr_q, 1'b1};
                        st       <= SQ_RADDR;
                    end
                end
                SQ_RADDR: begin
                    if (eng_done) begin
                        cmd_vld <= 1'b1;
                        if (eng_ack) begin
                            cmd_sel <= BC_READ;
                            cmd_ack <= (left_q > CNT_ONE);
                            st      <= SQ_DATA;
                        end else begin
                            cmd_sel <= BC_STOP;
                            fail_q  <= 1'b1;
                            st      <= SQ_STOP;
                        end
                    end
                end
                SQ_DATA: begin
                    if (eng_done) begin
                        rd_valid <= 1'b1;
                        rd_data  <= eng_rx;
                        cmd_vld  <= 1'b1;
                        if (left_q == CNT_ONE) begin
                            cmd_sel <= BC_STOP;
                            st      <= SQ_STOP;
                        end else begin
                            left_q  <= left_q - CNT_ONE;
                            cmd_sel <= BC_READ;
                            cmd_ack <= (left_q > CNT_TWO);
                        end
                    end
                end
                SQ_STOP: begin
                    if (eng_done) begin
                        done     <= 1'b1;
                        nack_err <= fail_q;
                        st       <= SQ_IDLE;
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    // R11: busy only drops together with the done pulse
    a_r11_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R11: done is never raised while a command is still running
    a_r11_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R3: data strobes only inside a command
    a_r3_valid_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> busy);

    // R6: the error pulse accompanies the completion pulse
    a_r6_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        nack_err |-> done);

    // R9: a zero-count strobe in idle does not start a command
    a_r9_zero_count_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && go && (rd_count == '0)) |=> !busy);

endmodule

// File: tb/tb_i2c_rdseq.sv
// Bench: behavioural open-drain slave with computed memory, random and
// directed commands, expectations computed from the requirements.
module tb_i2c_rdseq;

    localparam logic [6:0] SLV = 7'h2D;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] quarter_div = 8'd1;
    logic       go = 1'b0;
    logic       use_index = 1'b0;
    logic [6:0] dev_addr = SLV;
    logic [7:0] reg_index = 8'h00;
    logic [7:0] rd_count = 8'd1;
    logic       busy, done, nack_err, rd_valid;
    logic [7:0] rd_data;
    logic       scl_pull, sda_pull, sda_in;
    logic       slv_pull = 1'b0;
    logic       scl_line, sda_line;

    assign scl_line = !scl_pull;
    assign sda_line = !(sda_pull || slv_pull);
    assign sda_in   = sda_line;

    always #10 clk = !clk;

    i2c_rdseq dut (
        .clk(clk), .rst_n(rst_n), .quarter_div(quarter_div), .go(go),
        .use_index(use_index), .dev_addr(dev_addr), .reg_index(reg_index),
        .rd_count(rd_count), .busy(busy), .done(done), .nack_err(nack_err),
        .rd_valid(rd_valid), .rd_data(rd_data), .scl_pull(scl_pull),
        .sda_pull(sda_pull), .sda_in(sda_in)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    function automatic logic [7:0] mem_val(input logic [7:0] a);
        return (a * 8'd29) ^ 8'hA5;
    endfunction

    task automatic chk_eq(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // ---------------- slave model and bus monitor ----------------
    int         sl_state = 0;   // 0 idle, 1 address, 2 index, 3 hold, 4 send
    int         sl_bit = 0;
    bit         sl_skip = 1'b0;
    logic [7:0] sl_sh = 8'h00;
    logic [7:0] sl_tx = 8'h00;
    logic [7:0] sl_ptr = 8'h00;
    bit         sl_macked = 1'b0;
    bit         nack_index = 1'b0;
    logic       prev_scl = 1'b1, prev_sda = 1'b1;
    logic [7:0] rcv_log [0:7];
    int         rcv_n = 0, starts = 0, stops = 0, hi_edges = 0;
    int         m_ack = 0, m_nack = 0;
    int         hi_run = 0, hi_min = 1000000, hi_max = 0;
    bit         hi_on = 1'b0;
    logic [7:0] got [0:15];
    int         got_n = 0, done_n = 0;
    bit         err_seen = 1'b0;

    always @(negedge clk) begin
        if (!rst_n) begin
            prev_scl = 1'b1; prev_sda = 1'b1; sl_state = 0; slv_pull = 1'b0;
        end else begin
            if (scl_line && prev_scl && prev_sda && !sda_line) begin
                starts++; hi_edges++; sl_state = 1; sl_bit = 0; sl_skip = 1'b1;
                slv_pull = 1'b0;
            end else if (scl_line && prev_scl && !prev_sda && sda_line) begin
                stops++; hi_edges++; sl_state = 0; hi_on = 1'b0; slv_pull = 1'b0;
            end
            if (scl_line && !prev_scl) begin
                hi_on = 1'b1; hi_run = 1;
                if (sl_bit < 8) sl_sh = {sl_sh[6:0], sda_line};
                else if (sl_state == 4) begin
                    sl_macked = !sda_line;
                    if (!sda_line) m_ack++; else m_nack++;
                end
            end else if (scl_line && hi_on) begin
                hi_run++;
            end
            if (!scl_line && prev_scl) begin
                if (hi_on) begin
                    if (hi_run < hi_min) hi_min = hi_run;
                    if (hi_run > hi_max) hi_max = hi_run;
                    hi_on = 1'b0;
                end
                if (sl_skip) begin
                    sl_skip = 1'b0;
                end else if (sl_state != 0) begin
                    if (sl_bit == 7) begin
                        if (sl_state == 1 || sl_state == 2) begin
                            if (rcv_n < 8) rcv_log[rcv_n] = sl_sh;
                            rcv_n++;
                        end
                        if (sl_state == 1) slv_pull = (sl_sh[7:1] == SLV);
                        else if (sl_state == 2) slv_pull = !nack_index;
                        else slv_pull = 1'b0;
                        sl_bit = 8;
                    end else if (sl_bit == 8) begin
                        slv_pull = 1'b0;
                        sl_bit = 0;
                        if (sl_state == 1) begin
                            if (sl_sh[7:1] != SLV) sl_state = 0;
                            else if (sl_sh[0]) begin
                                sl_state = 4; sl_tx = mem_val(sl_ptr); slv_pull = !sl_tx[7];
                            end else sl_state = 2;
                        end else if (sl_state == 2) begin
                            if (!nack_index) sl_ptr = sl_sh;
                            sl_state = 3;
                        end else if (sl_state == 4) begin
                            sl_ptr = sl_ptr + 8'd1;
                            if (sl_macked) begin
                                sl_tx = mem_val(sl_ptr); slv_pull = !sl_tx[7];
                            end else sl_state = 0;
                        end
                    end else begin
                        sl_bit++;
                        if (sl_state == 4) slv_pull = !sl_tx[7 - sl_bit];
                    end
                end
            end
            prev_scl = scl_line;
            prev_sda = sda_line;
        end
    end

    // Collect DUT outputs away from the active edge
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (got_n < 16) got[got_n] = rd_data;
            got_n++;
        end
        if (rst_n && done) begin
            done_n++;
            err_seen = nack_err;
        end
    end

    task automatic clear_logs();
        rcv_n = 0; starts = 0; stops = 0; hi_edges = 0; m_ack = 0; m_nack = 0;
        hi_min = 1000000; hi_max = 0; got_n = 0;
    endtask

    logic [7:0] exp_ptr = 8'h00;

    task automatic run_txn(input logic [6:0] a, input logic [7:0] ix, input int n,
                           input bit md, input int dv, input bit nix, input bit poke);
        int d0;
        int w;
        bit err_a, err_i, err;
        logic [7:0] base;
        @(negedge clk);
        clear_logs();
        quarter_div = 8'(dv);
        nack_index = nix;
        dev_addr = a; reg_index = ix; rd_count = 8'(n); use_index = md;
        d0 = done_n;
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        chk_eq("R11 busy after go", int'(busy), 1);
        if (poke) begin
            repeat (40) @(negedge clk);
            dev_addr = a ^ 7'h11; reg_index = ix + 8'd50; rd_count = 8'(n + 3);
            use_index = !md; go = 1'b1;
            @(negedge clk);
            go = 1'b0;
            dev_addr = a; reg_index = ix; rd_count = 8'(n); use_index = md;
        end
        w = 0;
        while (done_n == d0 && w < 40000) begin
            @(negedge clk);
            w++;
        end
        chk_eq("R11 one done pulse", done_n - d0, 1);
        chk_eq("R11 busy low with done", int'(busy), 0);
        err_a = (a != SLV);
        err_i = md && !err_a && nix;
        err = err_a || err_i;
        chk_eq("R6 error pulse", int'(err_seen), int'(err));
        chk_eq("R3 byte count", got_n, err ? 0 : n);
        base = md ? ix : exp_ptr;
        if (!err) begin
            for (int i = 0; i < n; i++)
                chk_eq("R3 data byte", int'(got[i]), int'(mem_val(base + 8'(i))));
            chk_eq("R4 master acks", m_ack, n - 1);
            chk_eq("R4 final nack", m_nack, 1);
            exp_ptr = base + 8'(n);
        end
        chk_eq("R1 R2 stop count", stops, 1);
        if (md) begin
            chk_eq("R1 start count", starts, err ? 1 : 2);
            chk_eq("R1 logged bytes", rcv_n, err_a ? 1 : (err_i ? 2 : 3));
            chk_eq("R1 write address byte", int'(rcv_log[0]), int'({a, 1'b0}));
            if (!err_a) chk_eq("R1 index byte", int'(rcv_log[1]), int'(ix));
            if (!err) chk_eq("R1 read address byte", int'(rcv_log[2]), int'({a, 1'b1}));
        end else begin
            chk_eq("R2 start count", starts, 1);
            chk_eq("R2 logged bytes", rcv_n, 1);
            chk_eq("R2 read address byte", int'(rcv_log[0]), int'({a, 1'b1}));
        end
        chk_eq("R5 sda edges with scl high", hi_edges, starts + stops);
        chk_eq("R7 scl high min", hi_min, 2 * (dv + 1));
        chk_eq("R7 scl high max", hi_max, 2 * (dv + 1));
        chk_eq("R8 scl released", int'(scl_pull), 0);
        chk_eq("R8 sda released", int'(sda_pull), 0);
        if (poke) begin
            repeat (60) @(negedge clk);
            chk_eq("R10 no second command", int'(busy), 0);
            chk_eq("R10 done count", done_n - d0, 1);
        end
    endtask

    initial begin
        int unsigned sd;
        sd = $urandom(32'd4711);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_eq("R8 reset scl", int'(scl_pull), 0);
        chk_eq("R8 reset sda", int'(sda_pull), 0);
        chk_eq("R11 reset busy", int'(busy), 0);

        // R9: zero count is ignored
        clear_logs();
        begin
            int d0;
            d0 = done_n;
            rd_count = 8'd0; go = 1'b1;
            @(negedge clk);
            go = 1'b0;
            repeat (80) @(negedge clk);
            chk_eq("R9 busy stays low", int'(busy), 0);
            chk_eq("R9 no done", done_n - d0, 0);
            chk_eq("R9 bus idle", starts, 0);
        end

        // Directed corner cases
        run_txn(SLV, 8'h10, 1, 1'b1, 1, 1'b0, 1'b0);   // R1 single byte indexed
        run_txn(SLV, 8'hFE, 4, 1'b1, 0, 1'b0, 1'b0);   // R1 index wrap
        run_txn(SLV, 8'h00, 1, 1'b0, 2, 1'b0, 1'b0);   // R2 single byte plain
        run_txn(SLV, 8'h00, 3, 1'b0, 3, 1'b0, 1'b0);   // R2 continues from pointer
        run_txn(7'h11, 8'h40, 3, 1'b1, 1, 1'b0, 1'b0); // R6 address refused, indexed
        run_txn(7'h12, 8'h40, 2, 1'b0, 0, 1'b0, 1'b0); // R6 address refused, plain
        run_txn(SLV, 8'h40, 3, 1'b1, 1, 1'b1, 1'b0);   // R6 index refused
        run_txn(SLV, 8'h22, 3, 1'b1, 2, 1'b0, 1'b1);   // R10 go while busy

        // Constrained random commands
        for (int k = 0; k < 14; k++) begin
            run_txn(($urandom % 8 == 0) ? 7'h33 : SLV, 8'($urandom),
                    1 + int'($urandom % 6), 1'($urandom % 2),
                    int'($urandom % 4), ($urandom % 8 == 0), 1'b0);
        end

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (180000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule